// File: doc/BRIEF.md
# Management Bus Frame Monitor

This block listens passively to a two-wire station management bus, which has a slow clock line and a bidirectional data line. It never drives either line. Both lines are treated as asynchronous, so they are passed through synchronising registers into the system clock domain. A data bit is taken each time the bus clock rises.

After a long run of idle ones, a frame follows. The monitor first works out which of the two frame formats is in use: the legacy direct-register format or the extended indirect-address format. It then splits the frame into its fields. When the frame finishes, the monitor gives a single-cycle report of every field, together with flags for an illegal opcode and a bad turnaround bit.

For extended frames, the monitor also keeps the register address most recently set on the bus. Later reads, writes and post-increment reads act on that address. A start that arrives without enough preamble gives an error pulse in place of a report.

Top module: `mdio_frame_monitor`

## Requirements
- R1: A data bit is taken only on a rising edge of the bus clock. Data-line changes while the clock is steady, high or low, or falling have no effect on any output.
- R2: A frame begins when a 0 arrives after at least 32 consecutive 1 bits. A run of exactly 32 ones is enough, and a longer run also works.
- R3: The bit after that first 0 selects the format. A 1 gives a legacy frame (`frm_c45_o`=0). A 0 gives an extended frame (`frm_c45_o`=1).
- R4: The fields are shifted in MSB first, in this order: 2-bit opcode, 5-bit port address, 5-bit device/register address, 2 turnaround bits, then a 16-bit data word. All fields appear on the outputs while `frm_valid_o` is high, and that pulse lasts exactly one cycle.
- R5: Legacy opcodes 01 (write) and 10 (read) are legal. Legacy opcodes 00 and 11 set `frm_op_bad_o`, and the frame is still decoded and reported. Every extended opcode is legal: 00 address, 01 write, 11 read, 10 read with post-increment.
- R6: For write-type frames (legacy 01, extended 00 or 01), a first turnaround bit of 0 sets `frm_ta_bad_o`. For all other opcodes the turnaround bits are ignored.
- R7: An extended address frame (opcode 00) stores its data word as the current address and sets `c45_addr_known_o`. Before the first such frame, the known flag is 0 and the address is 0. Legacy frames never change the address.
- R8: An extended post-increment read (opcode 10) adds one to the stored address after the frame, but only when the address is known. An unknown address stays unknown.
- R9: A 0 that follows a run of 1 to 31 ones gives a one-cycle `frm_err_o` pulse and no `frm_valid_o`, and the preamble search starts again.
- R10: After synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_i | input | 1 | Bus clock line, asynchronous |
| mdio_i | input | 1 | Bus data line, asynchronous |
| frm_valid_o | output | 1 | One-cycle pulse when a complete frame has been decoded |
| frm_err_o | output | 1 | One-cycle pulse on a start with a short preamble |
| frm_c45_o | output | 1 | 1 for an extended-format frame |
| frm_op_o | output | 2 | Opcode field |
| frm_port_o | output | 5 | Port / PHY address field |
| frm_dev_o | output | 5 | Device address (extended) or register address (legacy) |
| frm_data_o | output | 16 | Data word |
| frm_op_bad_o | output | 1 | Opcode not legal for the detected format |
| frm_ta_bad_o | output | 1 | First turnaround bit wrong for a write-type frame |
| c45_addr_o | output | 16 | Stored extended register address |
| c45_addr_known_o | output | 1 | Stored address has been set by an address frame |

## Verification
Every result appears a fixed number of system clock edges after the bus clock rise that carries the frame's last bit. The frame report and any error pulse rise on the third edge after that rise: two synchroniser stages, then the decoder register. The stored extended address changes on the fourth edge. The bench holds each bus clock phase for six system cycles, so both results settle before the bus clock falls. A monitor at the falling system clock edge latches every report and counts the pulses and back-to-back highs. Each check therefore reads settled values only after the bit-driving task has returned.

// File: rtl/mdio_mon_pkg.sv
package mdio_mon_pkg;

    localparam int OP_W   = 2;
    localparam int PORT_W = 5;
    localparam int DEV_W  = 5;
    localparam int DATA_W = 16;

    // opcode encodings
    localparam logic [1:0] LEG_WR  = 2'b01;
    localparam logic [1:0] LEG_RD  = 2'b10;
    localparam logic [1:0] EXT_ADR = 2'b00;
    localparam logic [1:0] EXT_WR  = 2'b01;
    localparam logic [1:0] EXT_RDI = 2'b10;

    typedef enum logic [2:0] {
        S_PRE, S_ST, S_OP, S_PA, S_DA, S_TA, S_DAT
    } mon_state_e;

    typedef struct packed {
        logic              c45;
        logic [OP_W-1:0]   op;
        logic [PORT_W-1:0] port;
        logic [DEV_W-1:0]  dev;
        logic [DATA_W-1:0] data;
        logic              op_bad;
        logic              ta_bad;
    } frame_t;

    function automatic logic op_legal(input logic c45, input logic [OP_W-1:0] op);
        return c45 ? 1'b1 : (op == LEG_WR || op == LEG_RD);
    endfunction

    function automatic logic write_type(input logic c45, input logic [OP_W-1:0] op);
        return c45 ? (op == EXT_ADR || op == EXT_WR) : (op == LEG_WR);
    endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic bit_stb_o,
    output logic bit_val_o
);
    logic [STAGES-1:0] mdc_q;
    logic [STAGES-1:0] mdio_q;
    logic              mdc_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q    <= '0;
            mdio_q   <= '0;
            mdc_last <= 1'b0;
        end else begin
            mdc_q    <= {mdc_q[STAGES-2:0], mdc_i};
            mdio_q   <= {mdio_q[STAGES-2:0], mdio_i};
            mdc_last <= mdc_q[STAGES-1];
        end
    end

    assign bit_stb_o = mdc_q[STAGES-1] & ~mdc_last;
    assign bit_val_o = mdio_q[STAGES-1];

    // R1
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb_o |=> !bit_stb_o);

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mon_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   stb_i,
    input  logic   bit_i,
    output frame_t frm_o,
    output logic   valid_o,
    output logic   err_o
);
    localparam int CNT_W = $clog2(PRE_LEN + 1);
    localparam int FLD_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] ONES_FULL = CNT_W'(PRE_LEN);

    mon_state_e       state;
    logic [CNT_W-1:0] ones;
    logic [FLD_W-1:0] cnt;
    frame_t           cur;
    frame_t           done;

    always_comb begin
        done      = cur;
        done.data = {cur.data[DATA_W-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_PRE;
            ones    <= '0;
            cnt     <= '0;
            cur     <= '0;
            frm_o   <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (stb_i) begin
                unique case (state)
                    S_PRE: begin
                        if (bit_i) begin
                            if (ones != ONES_FULL) ones <= ones + 1'b1;
                        end else begin
                            if (ones == ONES_FULL) begin
                                state <= S_ST;
                                cur   <= '0;
                            end else if (ones != '0) begin
                                err_o <= 1'b1;
                            end
                            ones <= '0;
                        end
                    end
                    S_ST: begin
                        cur.c45 <= ~bit_i;
                        cnt     <= '0;
                        state   <= S_OP;
                    end
                    S_OP: begin
                        cur.op <= {cur.op[0], bit_i};
                        if (cnt == FLD_W'(OP_W - 1)) begin
                            cur.op_bad <= ~op_legal(cur.c45, {cur.op[0], bit_i});
                            cnt        <= '0;
                            state      <= S_PA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PA: begin
                        cur.port <= {cur.port[PORT_W-2:0], bit_i};
                        if (cnt == FLD_W'(PORT_W - 1)) begin
                            cnt   <= '0;
                            state <= S_DA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DA: begin
                        cur.dev <= {cur.dev[DEV_W-2:0], bit_i};
                        if (cnt == FLD_W'(DEV_W - 1)) begin
                            cnt   <= '0;
                            state <= S_TA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_TA: begin
                        if (cnt == '0) begin
                            cur.ta_bad <= write_type(cur.c45, cur.op) & ~bit_i;
                            cnt        <= cnt + 1'b1;
                        end else begin
                            cnt   <= '0;
                            state <= S_DAT;
                        end
                    end
                    S_DAT: begin
                        cur.data <= done.data;
                        if (cnt == FLD_W'(DATA_W - 1)) begin
                            frm_o   <= done;
                            valid_o <= 1'b1;
                            ones    <= '0;
                            cnt     <= '0;
                            state   <= S_PRE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= S_PRE;
                endcase
            end
        end
    end

    // R1
    edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> $stable(state));

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R9
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !valid_o);

    // R5
    ext_op_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && frm_o.c45) |-> !frm_o.op_bad);

endmodule

// File: rtl/mdio_c45_tracker.sv
module mdio_c45_tracker
    import mdio_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              c45_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] addr_o,
    output logic              known_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o  <= '0;
            known_o <= 1'b0;
        end else if (valid_i && c45_i) begin
            if (op_i == EXT_ADR) begin
                addr_o  <= data_i;
                known_o <= 1'b1;
            end else if (op_i == EXT_RDI && known_o) begin
                addr_o <= addr_o + 1'b1;
            end
        end
    end

    // R7
    known_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(known_o));

    // R7
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && c45_i && op_i == EXT_ADR) |=> addr_o == $past(data_i));

    // R7
    legacy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !c45_i) |=> $stable(addr_o));

    // R8
    rdi_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && c45_i && op_i == EXT_RDI && known_o) |=> addr_o == $past(addr_o) + 16'd1);

endmodule

// File: rtl/mdio_frame_monitor.sv
module mdio_frame_monitor
    import mdio_mon_pkg::*;
#(
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc_i,
    input  logic              mdio_i,
    output logic              frm_valid_o,
    output logic              frm_err_o,
    output logic              frm_c45_o,
    output logic [OP_W-1:0]   frm_op_o,
    output logic [PORT_W-1:0] frm_port_o,
    output logic [DEV_W-1:0]  frm_dev_o,
    output logic [DATA_W-1:0] frm_data_o,
    output logic              frm_op_bad_o,
    output logic              frm_ta_bad_o,
    output logic [DATA_W-1:0] c45_addr_o,
    output logic              c45_addr_known_o
);
    logic   stb;
    logic   bit_val;
    frame_t frm;

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .mdc_i(mdc_i), .mdio_i(mdio_i),
        .bit_stb_o(stb), .bit_val_o(bit_val)
    );

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) fsm_i (
        .clk(clk), .rst(rst), .stb_i(stb), .bit_i(bit_val),
        .frm_o(frm), .valid_o(frm_valid_o), .err_o(frm_err_o)
    );

    mdio_c45_tracker trk_i (
        .clk(clk), .rst(rst), .valid_i(frm_valid_o),
        .c45_i(frm.c45), .op_i(frm.op), .data_i(frm.data),
        .addr_o(c45_addr_o), .known_o(c45_addr_known_o)
    );

    assign frm_c45_o    = frm.c45;
    assign frm_op_o     = frm.op;
    assign frm_port_o   = frm.port;
    assign frm_dev_o    = frm.dev;
    assign frm_data_o   = frm.data;
    assign frm_op_bad_o = frm.op_bad;
    assign frm_ta_bad_o = frm.ta_bad;

endmodule

// File: tb/mdio_frame_monitor_tb.sv
module mdio_frame_monitor_tb_top;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdc = 1'b0;
    logic        mdio = 1'b1;
    logic        frm_valid_o, frm_err_o, frm_c45_o, frm_op_bad_o, frm_ta_bad_o, c45_addr_known_o;
    logic [1:0]  frm_op_o;
    logic [4:0]  frm_port_o, frm_dev_o;
    logic [15:0] frm_data_o, c45_addr_o;

    always #5 clk = ~clk;

    mdio_frame_monitor dut_i (
        .clk(clk), .rst(rst), .mdc_i(mdc), .mdio_i(mdio),
        .frm_valid_o(frm_valid_o), .frm_err_o(frm_err_o), .frm_c45_o(frm_c45_o),
        .frm_op_o(frm_op_o), .frm_port_o(frm_port_o), .frm_dev_o(frm_dev_o),
        .frm_data_o(frm_data_o), .frm_op_bad_o(frm_op_bad_o), .frm_ta_bad_o(frm_ta_bad_o),
        .c45_addr_o(c45_addr_o), .c45_addr_known_o(c45_addr_known_o)
    );

    typedef struct packed {
        logic        c45;
        logic [1:0]  op;
        logic [4:0]  pa;
        logic [4:0]  da;
        logic        ta1;
        logic [15:0] data;
        logic        xob;
        logic        xtb;
        logic        xknown;
        logic [15:0] xaddr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{1'b0, 2'b01, 5'h11, 5'h03, 1'b1, 16'hA5C3, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{1'b0, 2'b10, 5'h1F, 5'h00, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{1'b0, 2'b01, 5'h01, 5'h1E, 1'b0, 16'h8001, 1'b0, 1'b1, 1'b0, 16'h0000},
        '{1'b0, 2'b11, 5'h0A, 5'h15, 1'b0, 16'h7FFE, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{1'b1, 2'b00, 5'h02, 5'h01, 1'b1, 16'h0100, 1'b0, 1'b0, 1'b1, 16'h0100},
        '{1'b1, 2'b01, 5'h02, 5'h01, 1'b0, 16'hBEEF, 1'b0, 1'b1, 1'b1, 16'h0100},
        '{1'b1, 2'b11, 5'h02, 5'h01, 1'b0, 16'h5555, 1'b0, 1'b0, 1'b1, 16'h0100},
        '{1'b1, 2'b10, 5'h02, 5'h01, 1'b0, 16'hAAAA, 1'b0, 1'b0, 1'b1, 16'h0101}
    };

    int total = 0;
    int bad = 0;
    int nvalid = 0;
    int nerr = 0;
    int dbl = 0;
    logic prev_v = 1'b0;
    logic glitch = 1'b0;
    logic        cap_c45, cap_ob, cap_tb;
    logic [1:0]  cap_op;
    logic [4:0]  cap_pa, cap_da;
    logic [15:0] cap_data;

    // frame report monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (frm_valid_o) begin
                nvalid++;
                cap_c45  = frm_c45_o;
                cap_op   = frm_op_o;
                cap_pa   = frm_port_o;
                cap_da   = frm_dev_o;
                cap_data = frm_data_o;
                cap_ob   = frm_op_bad_o;
                cap_tb   = frm_ta_bad_o;
            end
            if (frm_valid_o && prev_v) dbl++;
            if (frm_err_o) nerr++;
            prev_v = frm_valid_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        mdio = b;
        repeat (HALF) @(negedge clk);
        mdc = 1'b1;
        repeat (HALF / 2) @(negedge clk);
        if (glitch) mdio = ~b;
        repeat (HALF - HALF / 2) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic send_frame(input int npre, input logic c45, input logic [1:0] op,
                              input logic [4:0] pa, input logic [4:0] da,
                              input logic ta1, input logic [15:0] data);
        for (int i = 0; i < npre; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(~c45);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(da[i]);
        send_bit(ta1);
        send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(data[i]);
        mdio = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nv0;
        int ne0;
        repeat (5) @(negedge clk);
        // R10 reset state
        chk(frm_valid_o == 0 && frm_err_o == 0 && frm_c45_o == 0 && frm_op_o == 0, "R10 flags", 0, 0);
        chk(frm_port_o == 0 && frm_dev_o == 0 && frm_data_o == 0, "R10 fields", {frm_port_o, frm_dev_o}, 0);
        chk(frm_op_bad_o == 0 && frm_ta_bad_o == 0, "R10 errflags", {frm_op_bad_o, frm_ta_bad_o}, 0);
        chk(c45_addr_o == 0 && c45_addr_known_o == 0, "R10 addr", c45_addr_o, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R8: post-increment read with unknown address keeps it unknown
        nv0 = nvalid;
        send_frame(32, 1'b1, 2'b10, 5'h04, 5'h07, 1'b0, 16'h00F0);
        chk(nvalid == nv0 + 1, "R8 rdi-unknown valid", nvalid - nv0, 1);
        chk(c45_addr_known_o == 0 && c45_addr_o == 0, "R8 rdi-unknown addr",
            {c45_addr_known_o, c45_addr_o}, 0);

        // R1: data line activity without clock edges
        nv0 = nvalid;
        ne0 = nerr;
        for (int i = 0; i < 40; i++) begin
            mdio = ~mdio;
            repeat (3) @(negedge clk);
        end
        mdc = 1'b1;
        for (int i = 0; i < 40; i++) begin
            mdio = ~mdio;
            repeat (3) @(negedge clk);
        end
        mdio = 1'b1;
        repeat (4) @(negedge clk);
        mdc = 1'b0;
        repeat (4) @(negedge clk);
        chk(nvalid == nv0 && nerr == ne0, "R1 no edge no report", nvalid - nv0 + nerr - ne0, 0);

        // table walk, data line toggled in the high clock phase (R1)
        glitch = 1'b1;
        for (int k = 0; k < NV; k++) begin
            nv0 = nvalid;
            send_frame(32, VT[k].c45, VT[k].op, VT[k].pa, VT[k].da, VT[k].ta1, VT[k].data);
            chk(nvalid == nv0 + 1, "R2 R4 one report", nvalid - nv0, 1);
            chk(cap_c45 == VT[k].c45, "R3 format", cap_c45, VT[k].c45);
            chk(cap_op == VT[k].op && cap_pa == VT[k].pa && cap_da == VT[k].da,
                "R4 addr fields", {cap_op, cap_pa, cap_da}, {VT[k].op, VT[k].pa, VT[k].da});
            chk(cap_data == VT[k].data, "R4 data R1", cap_data, VT[k].data);
            chk(cap_ob == VT[k].xob, "R5 op flag", cap_ob, VT[k].xob);
            chk(cap_tb == VT[k].xtb, "R6 ta flag", cap_tb, VT[k].xtb);
            chk(c45_addr_known_o == VT[k].xknown, "R7 known", c45_addr_known_o, VT[k].xknown);
            chk(c45_addr_o == VT[k].xaddr, "R7 R8 addr", c45_addr_o, VT[k].xaddr);
        end
        glitch = 1'b0;

        // R9: 31 ones then a start
        nv0 = nvalid;
        ne0 = nerr;
        send_frame(31, 1'b0, 2'b01, 5'h03, 5'h03, 1'b1, 16'hFFFF);
        chk(nvalid == nv0, "R9 no report", nvalid - nv0, 0);
        chk(nerr > ne0, "R9 error pulse", nerr - ne0, 1);

        // R2: longer preamble, R7: legacy frame keeps address
        nv0 = nvalid;
        send_frame(45, 1'b0, 2'b10, 5'h07, 5'h09, 1'b0, 16'h0F0F);
        chk(nvalid == nv0 + 1 && cap_data == 16'h0F0F, "R2 long preamble", cap_data, 16'h0F0F);
        chk(c45_addr_o == 16'h0101 && c45_addr_known_o == 1, "R7 legacy keeps addr", c45_addr_o, 16'h0101);

        // R8: second post-increment
        send_frame(32, 1'b1, 2'b10, 5'h02, 5'h01, 1'b0, 16'h0000);
        chk(c45_addr_o == 16'h0102, "R8 second increment", c45_addr_o, 16'h0102);

        // R4: every report lasted one cycle
        chk(dbl == 0, "R4 pulse width", dbl, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule